// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Commit Strobe

This block derives two slower clock enables from one parent clock. Each channel is set by a 5-bit code. The multiplier is 32 minus the code, so it runs from 1 to 32. In every 64-cycle frame of the parent clock, the channel's enable goes high on exactly that many cycles. The resulting rate is the parent rate times mult/32, followed by a fixed halving. A phase accumulator spreads the enable pulses as evenly as the frame allows.

Software writes both codes into one frequency register, where they wait as staged values. The codes reach the dividers only after a kick bit in a second register is set. The kick bit stays high while the change is pending. At the end of the current 64-cycle frame the block copies the staged codes into the active dividers and clears the kick bit on that same edge. While the kick bit is high the block counts as busy and ignores writes to the frequency register. A software driver therefore polls the kick bit before it starts the next change.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, both staged codes read 0, the kick bit reads 0, and each channel asserts its enable on 32 of every 64 cycles.
- R2: At address 0, bits 12:8 hold channel A's code and bits 4:0 hold channel B's code, with mult = 32 - code. All other bits of that address read 0. Channel A drives ce_o[0] and channel B drives ce_o[1].
- R3: In every 64-cycle frame counted from reset release, each channel asserts its enable on exactly mult cycles.
- R4: At frame position k (0..63), a channel's enable is high exactly when floor((k+1)*mult/64) > floor(k*mult/64).
- R5: A write to address 0 changes only the staged codes. The enable outputs keep their old rate until a kick commits the new codes.
- R6: Writing 1 to bit 31 at address 1 sets the kick bit. It reads back as 1 at bit 31 of address 1 until the commit, and a second such write while it is set leaves it at 1.
- R7: The commit happens on the edge that ends a frame (position 63 to 0). The new codes govern the enables from position 0, and the kick bit reads 0 from that same position.
- R8: A write to address 1 with bit 31 at 0 has no effect on the kick bit or on the enables.
- R9: While the kick bit is set, writes to address 0 are ignored. The readback keeps the staged value, and the commit applies that value.
- R10: The two channels are independent: each channel's enable count follows only its own code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address (0 frequency, 1 kick) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| ce_o | output | 2 | Clock enables: bit 0 channel A, bit 1 channel B |

## Verification
The hardest case to reach from the ports is a register write that arrives while a commit is pending. The write must be discarded, and the kick must then clear on a frame edge and not on the next cycle. The bench sets the kick and at once writes conflicting codes. It then polls the kick bit every cycle and checks that it clears exactly at frame position 0. A cycle-accurate model of the staged and active codes checks every enable cycle against the floor formula. The bench sweeps all 32 codes on channel A while channel B carries the complementary code.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned KICK_BIT = 31;
  localparam logic [ADDR_W-1:0] ADDR_FREQ = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_KICK = 2'd1;

  // channel 0 (A) decodes bits 12:8, channel 1 (B) bits 4:0
  function automatic int unsigned field_lsb(input int unsigned ch);
    return (ch == 0) ? 8 : 0;
  endfunction
endpackage

// File: rtl/frac_div_frame.sv
module frac_div_frame #(
  parameter int unsigned CNT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = &cnt_q;

  frame_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);
endmodule

// File: rtl/frac_div_regs.sv
module frac_div_regs
  import frac_div_pkg::*;
#(
  parameter int unsigned FIELD_W = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic                              frame_last_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_CH-1:0][FIELD_W-1:0]    active_o
);
  logic [NUM_CH-1:0][FIELD_W-1:0] staged_q, active_q;
  logic kick_q;
  logic commit, freq_wr, kick_wr;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign commit  = frame_last_i & kick_q;
  assign freq_wr = wr_en_i && (addr_i == ADDR_FREQ) && !kick_q;
  assign kick_wr = wr_en_i && (addr_i == ADDR_KICK) && wdata_i[KICK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
      active_q <= '0;
      kick_q   <= 1'b0;
    end else begin
      if (commit)       kick_q <= 1'b0;
      else if (kick_wr) kick_q <= 1'b1;
      if (commit) active_q <= staged_q;
      if (freq_wr) begin
        for (int c = 0; c < NUM_CH; c++)
          staged_q[c] <= wdata_i[field_lsb(c) +: FIELD_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_FREQ) begin
      for (int c = 0; c < NUM_CH; c++)
        rdata_o[field_lsb(c) +: FIELD_W] = staged_q[c];
    end else if (addr_i == ADDR_KICK) begin
      rdata_o[KICK_BIT] = kick_q;
    end
  end

  assign active_o = active_q;

  // R8
  kick_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kick_q && wr_en_i && addr_i == ADDR_KICK && !wdata_i[KICK_BIT]) |=> !kick_q);
  // R7
  kick_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(kick_q) |-> $past(frame_last_i));
  // R5
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(active_q));
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_q |=> $stable(staged_q));
endmodule

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
  parameter int unsigned FIELD_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] code_i,
  input  logic               frame_last_i,
  output logic               ce_o
);
  localparam int unsigned ACC_W = FIELD_W + 1;

  logic [ACC_W-1:0] acc_q, mult, ce_cnt_q;
  logic [ACC_W:0]   sum;

  assign mult = ACC_W'(1 << FIELD_W) - ACC_W'(code_i);
  assign sum  = {1'b0, acc_q} + {1'b0, mult};
  assign ce_o = sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_q <= '0;
    else if (frame_last_i) acc_q <= '0;
    else                   acc_q <= sum[ACC_W-1:0];
  end

  // pulse counter kept for checking only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ce_cnt_q <= '0;
    else if (frame_last_i) ce_cnt_q <= '0;
    else                   ce_cnt_q <= ce_cnt_q + ACC_W'(ce_o);
  end

  // R3
  frame_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_i |-> (ce_cnt_q + ACC_W'(ce_o)) == mult);
  // R4
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_i |-> sum[ACC_W-1:0] == '0);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int unsigned FIELD_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] ce_o
);
  localparam int unsigned CNT_W = FIELD_W + 1;

  logic frame_last;
  logic [NUM_CH-1:0][FIELD_W-1:0] active;

  frac_div_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_o (frame_last)
  );

  frac_div_regs #(.FIELD_W(FIELD_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .frame_last_i (frame_last),
    .rdata_o      (rdata_o),
    .active_o     (active)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    frac_div_accum #(.FIELD_W(FIELD_W)) u_accum (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .code_i       (active[c]),
      .frame_last_i (frame_last),
      .ce_o         (ce_o[c])
    );
  end
endmodule

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] ce;

  frac_clk_div uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ce_o(ce)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int pos = 0, m_kick = 0;
  int act_code [2] = '{0, 0};
  int st_code  [2] = '{0, 0};
  int run_cnt  [2] = '{0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ce(input int k, input int code);
    int m = 32 - code;
    return ((k + 1) * m / 64) > (k * m / 64);
  endfunction

  // reference model of staging, kick and frame position
  always @(posedge clk) begin
    if (!rst_n) begin
      pos <= 0; m_kick <= 0;
      act_code <= '{0, 0}; st_code <= '{0, 0};
    end else begin
      if (pos == 63 && m_kick != 0) begin
        act_code <= st_code; m_kick <= 0;
      end else if (wr_en && addr == 2'd1 && wdata[31]) m_kick <= 1;
      if (wr_en && addr == 2'd0 && m_kick == 0)
        st_code <= '{int'(wdata[12:8]), int'(wdata[4:0])};
      pos <= (pos + 1) % 64;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++) begin
        if (pos == 0) run_cnt[c] = 0;
        run_cnt[c] += int'(ce[c]);
        chk(ce[c] == exp_ce(pos, act_code[c]), "R4 pattern", int'(ce[c]),
            int'(exp_ce(pos, act_code[c])));
        if (pos == 63)
          chk(run_cnt[c] == 32 - act_code[c], "R3 frame count", run_cnt[c],
              32 - act_code[c]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic count_frame(output int n0, output int n1);
    n0 = 0; n1 = 0;
    do @(negedge clk); while (pos != 0);
    for (int i = 0; i < 64; i++) begin
      n0 += int'(ce[0]); n1 += int'(ce[1]);
      if (i != 63) @(negedge clk);
    end
  endtask

  task automatic wait_commit();
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(2'd1, d);
      if (!d[31]) break;
    end
    chk(d[31] == 1'b0, "R7 kick cleared", int'(d[31]), 0);
    chk(pos == 0, "R7 commit on frame edge", pos, 0);
  endtask

  task automatic apply(input int a, input int b);
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_E0E0 | (32'(a) << 8) | 32'(b));
    rd(2'd0, d);
    chk(d == ((32'(a) << 8) | 32'(b)), "R2 field readback", int'(d), (a << 8) | b);
    wr(2'd1, 32'h8000_0000);
    rd(2'd1, d);
    chk(d == 32'h8000_0000, "R6 kick pending", int'(d[31]), 1);
    wait_commit();
  endtask

  initial begin
    logic [31:0] d;
    int n0, n1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, d); chk(d == 0, "R1 fields reset", int'(d), 0);
    rd(2'd1, d); chk(d == 0, "R1 kick reset", int'(d), 0);
    count_frame(n0, n1);
    chk(n0 == 32, "R1 ch A full rate", n0, 32);
    chk(n1 == 32, "R1 ch B full rate", n1, 32);

    // R2 R3 R4: sweep every code on A, complement on B
    for (int code = 0; code < 32; code++) begin
      apply(code, 31 - code);
      count_frame(n0, n1);
      chk(n0 == 32 - code, "R3 sweep ch A", n0, 32 - code);
      chk(n1 == 1 + code, "R3 sweep ch B", n1, 1 + code);
    end

    // R10: independent channels
    apply(3, 20);
    count_frame(n0, n1);
    chk(n0 == 29, "R10 ch A", n0, 29);
    chk(n1 == 12, "R10 ch B", n1, 12);

    // R5: staged write without kick has no effect
    wr(2'd0, (32'd30 << 8) | 32'd0);
    repeat (70) @(negedge clk);
    count_frame(n0, n1);
    chk(n0 == 29, "R5 ch A unchanged", n0, 29);
    chk(n1 == 12, "R5 ch B unchanged", n1, 12);

    // R8: kick write with bit 31 clear
    wr(2'd1, 32'h7FFF_FFFF);
    rd(2'd1, d); chk(d[31] == 1'b0, "R8 kick stays clear", int'(d[31]), 0);
    count_frame(n0, n1);
    chk(n0 == 29, "R8 ch A unchanged", n0, 29);

    // R9 R6: writes while busy ignored, re-kick keeps pending
    do @(negedge clk); while (pos != 2);
    wr(2'd0, (32'd10 << 8) | 32'd16);
    wr(2'd1, 32'h8000_0000);
    wr(2'd0, (32'd1 << 8) | 32'd1);
    wr(2'd1, 32'h8000_0000);
    rd(2'd1, d); chk(d[31] == 1'b1, "R6 kick held", int'(d[31]), 1);
    rd(2'd0, d);
    chk(d == ((32'd10 << 8) | 32'd16), "R9 busy write ignored", int'(d), (10 << 8) | 16);
    wait_commit();
    count_frame(n0, n1);
    chk(n0 == 22, "R9 ch A committed", n0, 22);
    chk(n1 == 16, "R9 ch B committed", n1, 16);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule